// File: doc/BRIEF.md
# DCT Sum-of-Products Datapath

This block is the arithmetic core behind one output coefficient of an 8-point one-dimensional discrete cosine transform. For each of the eight terms an external sequencer presents a signed 16-bit sample and a signed 16-bit cosine operand. It then pulses a series of strobes on successive cycles. The first strobe latches the sign of the term, which is the XOR of the two operand sign bits. The second latches the unsigned product of the two magnitudes. The third adds the term into a 36-bit signed sum. For that last step the sequencer reads the exported sign flag and drives a negate select, which chooses the product or its two's complement as the term that is added.

A clear strobe zeroes the sum before a new coefficient starts. A DC-select line picks the output path. With DC-select high, for coefficient index zero, the sum is multiplied by a fixed-point approximation of 1/sqrt(2) (46341 / 2^16), rounded toward minus infinity and truncated to 36 bits. With DC-select low the raw sum is passed through. The output path has no register, so the result follows DC-select in the same cycle. An asynchronous active-low reset clears every register. Its release is synchronised to the clock through two flops.

Top module: `dct_sop_datapath`

## Requirements
- R1: While reset is asserted, and until the first strobe after its release, result_o and term_neg_o read zero.
- R2: On a clock edge with sign_en_i high, term_neg_o takes sample_i[15] XOR cosine_i[15]. It holds its value on every edge where sign_en_i is low.
- R3: On a clock edge with prod_en_i high, the product register loads |sample_i| * |cosine_i|, where -32768 counts as magnitude 32768. Changing the operands while prod_en_i is low does not affect the term that is later accumulated.
- R4: With neg_sel_i high the accumulated term is the negated product. With neg_sel_i low it is the product itself, whatever term_neg_o shows.
- R5: On an edge with acc_en_i high and acc_clr_i low, the sum becomes the old sum plus the selected term. With both strobes low the sum holds.
- R6: An edge with acc_clr_i high zeroes the sum. This also happens when acc_en_i is high in the same cycle.
- R7: With dc_sel_i low, result_o equals the 36-bit sum.
- R8: With dc_sel_i high, result_o equals floor(sum * 46341 / 65536), taken to 36 bits, in the same cycle as dc_sel_i changes.
- R9: After a clear and eight sign/product/accumulate sequences with neg_sel_i set from term_neg_o, the sum equals the signed integer dot product of the eight sample/cosine pairs. This includes all-minimum and all-maximum operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_i | input | 16 | Signed input sample |
| cosine_i | input | 16 | Signed cosine operand |
| sign_en_i | input | 1 | Latch the sign of the current term |
| prod_en_i | input | 1 | Latch the magnitude product |
| neg_sel_i | input | 1 | 1: add the negated product, 0: add the product |
| acc_en_i | input | 1 | Add the selected term into the sum |
| acc_clr_i | input | 1 | Zero the sum, with priority over acc_en_i |
| dc_sel_i | input | 1 | 1: scaled output for index zero, 0: raw sum |
| result_o | output | 36 | Coefficient result |
| term_neg_o | output | 1 | Registered sign of the current term |

## Verification
The checker watches several behaviours on every cycle. These are the hold of the sign flag, the product register and the sum when their strobes are low; the loading of the sign XOR; the exact sum update from the old sum, the product and the negate select; the priority of clear; and the raw pass-through path. The scaling by 1/sqrt(2), the magnitude arithmetic at the -32768 corner and the full eight-term coefficient against an integer dot product are only shown by the bench. It runs random and directed coefficients, each read through both output paths.

// File: rtl/dct_sop_pkg.sv
package dct_sop_pkg;

  // Default operand and sum widths.
  parameter int unsigned DEF_DATA_W  = 16;
  parameter int unsigned DEF_ACC_W   = 36;
  // 1/sqrt(2) in unsigned Q0.16 form, rounded to nearest.
  parameter int unsigned DEF_SCALE_K    = 46341;
  parameter int unsigned DEF_SCALE_FRAC = 16;

  // Term polarity chosen by the sequencer.
  typedef enum logic {
    TERM_ADD = 1'b0,
    TERM_SUB = 1'b1
  } term_pol_e;

endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dct_mag_mult.sv
module dct_mag_mult #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] cosine_i,
  input  logic                     sign_en_i,
  input  logic                     prod_en_i,
  output logic                     term_neg_o,
  output logic [PROD_W-1:0]        prod_o
);

  logic              sign_d, sign_q;
  logic [DATA_W-1:0] samp_mag, cos_mag;
  logic [PROD_W-1:0] prod_d, prod_q;

  // Magnitudes: the most negative value maps to 2^(DATA_W-1), which
  // still fits in DATA_W unsigned bits.
  always_comb begin
    samp_mag = sample_i[DATA_W-1] ? (~sample_i + 1'b1) : sample_i;
    cos_mag  = cosine_i[DATA_W-1] ? (~cosine_i + 1'b1) : cosine_i;
  end

  always_comb begin
    sign_d = sign_q;
    if (sign_en_i) begin
      sign_d = sample_i[DATA_W-1] ^ cosine_i[DATA_W-1];
    end
  end

  always_comb begin
    prod_d = prod_q;
    if (prod_en_i) begin
      prod_d = PROD_W'(samp_mag) * PROD_W'(cos_mag);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      prod_q <= '0;
    end else begin
      sign_q <= sign_d;
      prod_q <= prod_d;
    end
  end

  assign term_neg_o = sign_q;
  assign prod_o     = prod_q;

endmodule

// File: rtl/dct_term_acc.sv
module dct_term_acc
  import dct_sop_pkg::*;
#(
  parameter int unsigned PROD_W = 32,
  parameter int unsigned ACC_W  = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PROD_W-1:0]       prod_i,
  input  logic                    neg_sel_i,
  input  logic                    acc_en_i,
  input  logic                    acc_clr_i,
  output logic signed [ACC_W-1:0] sum_o
);

  term_pol_e               pol;
  logic signed [ACC_W-1:0] term_pos, term;
  logic signed [ACC_W-1:0] sum_d, sum_q;

  always_comb begin
    pol      = term_pol_e'(neg_sel_i);
    term_pos = $signed({{(ACC_W-PROD_W){1'b0}}, prod_i});
    case (pol)
      TERM_SUB: term = -term_pos;
      default:  term = term_pos;
    endcase
  end

  // Clear has priority over accumulate.
  always_comb begin
    sum_d = sum_q;
    if (acc_clr_i) begin
      sum_d = '0;
    end else if (acc_en_i) begin
      sum_d = sum_q + term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/dct_out_scale.sv
module dct_out_scale #(
  parameter int unsigned ACC_W      = 36,
  parameter int unsigned SCALE_K    = 46341,
  parameter int unsigned SCALE_FRAC = 16,
  localparam int unsigned K_W   = $clog2(SCALE_K + 1) + 1,
  localparam int unsigned MUL_W = ACC_W + K_W
) (
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic                    dc_sel_i,
  output logic signed [ACC_W-1:0] result_o
);

  localparam logic signed [K_W-1:0] K_S = K_W'(SCALE_K);

  logic signed [MUL_W-1:0] wide_prod;
  logic signed [MUL_W-1:0] wide_shift;
  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    wide_prod  = MUL_W'(sum_i) * MUL_W'(K_S);
    wide_shift = wide_prod >>> SCALE_FRAC;
    scaled     = wide_shift[ACC_W-1:0];
    result_o   = dc_sel_i ? scaled : sum_i;
  end

endmodule

// File: rtl/dct_sop_datapath.sv
module dct_sop_datapath
  import dct_sop_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned SCALE_K    = DEF_SCALE_K,
  parameter int unsigned SCALE_FRAC = DEF_SCALE_FRAC,
  localparam int unsigned PROD_W    = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       sample_i,
  input  logic [DATA_W-1:0]       cosine_i,
  input  logic                    sign_en_i,
  input  logic                    prod_en_i,
  input  logic                    neg_sel_i,
  input  logic                    acc_en_i,
  input  logic                    acc_clr_i,
  input  logic                    dc_sel_i,
  output logic [ACC_W-1:0]        result_o,
  output logic                    term_neg_o
);

  logic                    rst_n_sync;
  logic [PROD_W-1:0]       prod_w;
  logic signed [ACC_W-1:0] sum_w;
  logic signed [ACC_W-1:0] res_w;

  dct_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dct_mag_mult #(.DATA_W(DATA_W)) u_mult (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .sample_i   ($signed(sample_i)),
    .cosine_i   ($signed(cosine_i)),
    .sign_en_i  (sign_en_i),
    .prod_en_i  (prod_en_i),
    .term_neg_o (term_neg_o),
    .prod_o     (prod_w)
  );

  dct_term_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .prod_i    (prod_w),
    .neg_sel_i (neg_sel_i),
    .acc_en_i  (acc_en_i),
    .acc_clr_i (acc_clr_i),
    .sum_o     (sum_w)
  );

  dct_out_scale #(
    .ACC_W      (ACC_W),
    .SCALE_K    (SCALE_K),
    .SCALE_FRAC (SCALE_FRAC)
  ) u_scale (
    .sum_i    (sum_w),
    .dc_sel_i (dc_sel_i),
    .result_o (res_w)
  );

  assign result_o = res_w;

endmodule

// File: rtl/dct_sop_datapath_chk.sv
module dct_sop_datapath_chk #(
  parameter int unsigned PROD_W = 32,
  parameter int unsigned ACC_W  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              samp_sign,
  input logic              cos_sign,
  input logic              sign_en_i,
  input logic              prod_en_i,
  input logic              neg_sel_i,
  input logic              acc_en_i,
  input logic              acc_clr_i,
  input logic              dc_sel_i,
  input logic [PROD_W-1:0] prod_w,
  input logic [ACC_W-1:0]  sum_w,
  input logic [ACC_W-1:0]  result_o,
  input logic              term_neg_o
);

  logic [ACC_W-1:0] term_ext;
  assign term_ext = neg_sel_i ? (~{{(ACC_W-PROD_W){1'b0}}, prod_w} + 1'b1)
                              : {{(ACC_W-PROD_W){1'b0}}, prod_w};

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (result_o == '0 && !term_neg_o)); // R1

  AST_SIGN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sign_en_i |=> term_neg_o == ($past(samp_sign) ^ $past(cos_sign))); // R2

  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_en_i |=> $stable(term_neg_o)); // R2

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_en_i |=> $stable(prod_w)); // R3

  AST_SUM_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && !acc_clr_i) |=> sum_w == $past(sum_w) + $past(term_ext)); // R4

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en_i && !acc_clr_i) |=> $stable(sum_w)); // R5

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_i |=> sum_w == '0); // R6

  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !dc_sel_i |-> result_o == sum_w); // R7

endmodule

bind dct_sop_datapath dct_sop_datapath_chk #(
  .PROD_W (PROD_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .samp_sign  (sample_i[DATA_W-1]),
  .cos_sign   (cosine_i[DATA_W-1]),
  .sign_en_i  (sign_en_i),
  .prod_en_i  (prod_en_i),
  .neg_sel_i  (neg_sel_i),
  .acc_en_i   (acc_en_i),
  .acc_clr_i  (acc_clr_i),
  .dc_sel_i   (dc_sel_i),
  .prod_w     (prod_w),
  .sum_w      (sum_w),
  .result_o   (result_o),
  .term_neg_o (term_neg_o)
);

// File: tb/dct_sop_datapath_test.sv
`timescale 1ns/1ps
module dct_sop_datapath_test;

  localparam int DW = 16;
  localparam int AW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] sample_i, cosine_i;
  logic          sign_en_i, prod_en_i, neg_sel_i, acc_en_i, acc_clr_i, dc_sel_i;
  logic [AW-1:0] result_o;
  logic          term_neg_o;

  int     checks = 0;
  int     errors = 0;
  longint ref_sum = 0;
  bit     done = 1'b0;

  always #10 clk = ~clk;

  dct_sop_datapath uut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cosine_i(cosine_i),
    .sign_en_i(sign_en_i), .prod_en_i(prod_en_i), .neg_sel_i(neg_sel_i),
    .acc_en_i(acc_en_i), .acc_clr_i(acc_clr_i), .dc_sel_i(dc_sel_i),
    .result_o(result_o), .term_neg_o(term_neg_o)
  );

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint absv(input logic [DW-1:0] v);
    longint s = sx(v);
    return (s < 0) ? -s : s;
  endfunction

  function automatic logic [AW-1:0] scale_ref(input longint s);
    longint t;
    t = (s * 64'sd46341) >>> 16;
    return t[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] raw_ref(input longint s);
    return s[AW-1:0];
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reads both output paths at the current negedge.
  task automatic check_both(input string tag);
    dc_sel_i = 1'b0; #1;
    check({tag, " R7 raw"}, result_o, raw_ref(ref_sum));
    dc_sel_i = 1'b1; #1;
    check({tag, " R8 scaled"}, result_o, scale_ref(ref_sum));
    dc_sel_i = 1'b0;
  endtask

  task automatic clear_sum();
    @(negedge clk); acc_clr_i = 1'b1;
    @(negedge clk); acc_clr_i = 1'b0;
    ref_sum = 0;
  endtask

  // mode 0: normal, 1: neg_sel forced low, 2: operands disturbed after product latch
  task automatic do_term(input logic [DW-1:0] a, input logic [DW-1:0] b, input int mode);
    longint p;
    bit     neg;
    p   = absv(a) * absv(b);
    neg = a[DW-1] ^ b[DW-1];
    @(negedge clk);
    sample_i = a; cosine_i = b; sign_en_i = 1'b1;
    @(negedge clk);
    sign_en_i = 1'b0; prod_en_i = 1'b1;
    check("R2 sign flag", AW'(term_neg_o), AW'(neg));
    @(negedge clk);
    prod_en_i = 1'b0;
    if (mode == 2) begin
      sample_i = ~a; cosine_i = b + 16'd3;
    end
    neg_sel_i = (mode == 1) ? 1'b0 : term_neg_o;
    acc_en_i  = 1'b1;
    @(negedge clk);
    acc_en_i = 1'b0; neg_sel_i = 1'b0;
    if (mode != 1 && neg) ref_sum = ref_sum - p;
    else ref_sum = ref_sum + p;
  endtask

  task automatic coefficient(input string tag, input logic [DW-1:0] av[8], input logic [DW-1:0] bv[8]);
    clear_sum();
    for (int i = 0; i < 8; i++) do_term(av[i], bv[i], 0);
    check_both({tag, " R9"});
  endtask

  initial begin
    logic [DW-1:0] av[8];
    logic [DW-1:0] bv[8];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sample_i = '0; cosine_i = '0;
    sign_en_i = 0; prod_en_i = 0; neg_sel_i = 0; acc_en_i = 0; acc_clr_i = 0; dc_sel_i = 0;
    repeat (3) @(negedge clk);
    check("R1 reset result", result_o, '0);
    check("R1 reset sign", AW'(term_neg_o), '0);
    dc_sel_i = 1'b1; #1;
    check("R1 reset scaled", result_o, '0);
    dc_sel_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", result_o, '0);

    // Eight random coefficients
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 8; i++) begin
        av[i] = DW'($urandom);
        bv[i] = DW'($urandom);
      end
      coefficient($sformatf("rand coef %0d", c), av, bv);
    end

    // All most-negative operands: every product positive 2^30
    for (int i = 0; i < 8; i++) begin av[i] = 16'h8000; bv[i] = 16'h8000; end
    coefficient("all min", av, bv);
    // Max positive times most negative
    for (int i = 0; i < 8; i++) begin av[i] = 16'h7FFF; bv[i] = 16'h8000; end
    coefficient("max x min", av, bv);
    // All maximum
    for (int i = 0; i < 8; i++) begin av[i] = 16'h7FFF; bv[i] = 16'h7FFF; end
    coefficient("all max", av, bv);
    // All negative small values
    for (int i = 0; i < 8; i++) begin av[i] = 16'hFFFF - 16'(i); bv[i] = 16'hFF00 + 16'(i); end
    coefficient("all negative", av, bv);

    // R4: negative term added with neg_sel low adds the magnitude
    clear_sum();
    do_term(16'hFFF6, 16'd7, 1);
    check("R4 forced add", result_o, raw_ref(70));
    do_term(16'd5, 16'hFFFD, 0);
    check("R4 negated", result_o, raw_ref(55));

    // R3: operand change after product latch does not leak
    do_term(16'd100, 16'hFF38, 2);
    check("R3 product held", result_o, raw_ref(ref_sum));

    // R5/R2: idle operand activity without strobes changes nothing
    @(negedge clk);
    sample_i = 16'h8000; cosine_i = 16'h1234; neg_sel_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 sum held", result_o, raw_ref(ref_sum));
    check("R2 sign held", AW'(term_neg_o), AW'(1'b1));
    neg_sel_i = 1'b0;

    // R6: clear together with accumulate
    @(negedge clk);
    acc_clr_i = 1'b1; acc_en_i = 1'b1;
    @(negedge clk);
    acc_clr_i = 1'b0; acc_en_i = 1'b0;
    ref_sum = 0;
    check("R6 clear wins", result_o, '0);
    check_both("R6 after clear");

    // R8: scaled path on a negative sum (floor rounding)
    clear_sum();
    do_term(16'hFFFF, 16'd3, 0);
    check_both("R8 small negative");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule